// File: doc/BRIEF.md
# Core Voltage Supervisor with Coded Reference

This block turns a 5-bit voltage identification code into a core reference level in millivolts. It then judges digitized output-voltage samples against limits derived from that level. A controller uses three of its results to gate a regulator. The first is a registered power-good flag. The second is an immediate core over-voltage trip, which a fault sequencer elsewhere latches. The third is an inhibit flag for the one reserved code. A separate fixed-level clamp request drives the low-side switch while power-on reset is still in progress.

The code is taken once, on the first clock after reset is released. All tracking limits are computed from the decoded reference at that moment, using integer arithmetic, and stay fixed until the next reset. Each limit is floor(ref × pct / 100).

The core window has hysteresis on both sides. The I/O output has its own under-voltage monitor with hysteresis. Two external under-voltage flags for the linear outputs also drop power-good.

Top module: `core_vsup`

## Requirements
- R1: For codes with bit 4 = 1 (except 11111), ref_mv = 3500 − 100 × vid[3:0].
- R2: For codes with bit 4 = 0, ref_mv = 2050 − 50 × vid[3:0].
- R3: Code 11111 sets inhibit = 1 and ref_mv = 0. While inhibit is set, pgood is 1 (one cycle after capture) and ov_trip stays 0, whatever the samples are.
- R4: The core high side goes bad when core_mv > floor(ref×110/100). It recovers only when core_mv ≤ floor(ref×108/100).
- R5: The core low side goes bad when core_mv < floor(ref×91/100). It recovers only when core_mv ≥ floor(ref×93/100). After reset the low side starts bad.
- R6: The I/O output goes bad when io_mv < 2450. It recovers only when io_mv ≥ 2550. It starts bad.
- R7: pgood is 0 whenever por_done = 0 or either lin_uv bit (bit 0 or bit 1) is 1 at the sampling edge.
- R8: ov_trip = 1 in the same cycle that core_mv > floor(ref×115/100), provided por_done = 1, the code has been captured and inhibit = 0.
- R9: clamp_req = 1 exactly when por_done = 0 and core_mv > 1260, combinationally.
- R10: vid is sampled only on the first clock after reset is released. Later changes to vid do not alter ref_mv, inhibit or the limits.
- R11: pgood is a register. It is 0 on every clock where rst_n = 0. Otherwise it reflects the samples present at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vid | input | 5 | Voltage identification code |
| core_mv | input | 13 | Core output sample, millivolts |
| io_mv | input | 13 | I/O output sample, millivolts |
| lin_uv | input | 2 | Under-voltage flags of the two linear outputs |
| por_done | input | 1 | Power-on reset complete |
| ref_mv | output | 13 | Decoded core reference, millivolts |
| pgood | output | 1 | Power-good flag |
| ov_trip | output | 1 | Core over-voltage trip |
| clamp_req | output | 1 | Pre-reset clamp request to the low-side switch |
| inhibit | output | 1 | Reserved-code inhibit |

## Verification
The hardest states to reach are the hysteresis hold bands, where a sample sits between the trip and recovery limits. There the output depends on history, not on the present sample. The bench reaches them with ordered sample sequences run under a fresh reset for every one of the 32 codes. Each sequence first drives a side bad just past its trip limit, then steps back into the band, and only then crosses the recovery limit. The once-only capture is probed by changing the code mid-run. A sample that is good only under the original reference must keep power-good high.

// File: rtl/core_vsup_pkg.sv
// Shared types and arithmetic for the core voltage supervisor.
// Assumes all voltages are unsigned millivolt codes of MV_W bits.
package core_vsup_pkg;
    parameter int unsigned MV_W = 13;
    typedef logic [MV_W-1:0] mv_t;

    typedef enum logic {MON_UNDER = 1'b0, MON_OVER = 1'b1} mon_dir_e;

    // Limits that track the decoded reference.
    typedef struct packed {
        mv_t hi_trip;
        mv_t hi_clr;
        mv_t lo_trip;
        mv_t lo_clr;
        mv_t ov;
    } lim_t;

    // floor(r * pct / 100) in integer arithmetic.
    function automatic mv_t scale_pct(mv_t r, int unsigned pct);
        logic [31:0] prod;
        prod = 32'(r) * 32'(pct);
        return mv_t'(prod / 32'd100);
    endfunction
endpackage

// File: rtl/cv_vid_decode.sv
// Combinational decode of the 5-bit identification code into a millivolt reference.
// Assumes the all-ones code is reserved and yields inhibit with a zero reference.
module cv_vid_decode
    import core_vsup_pkg::*;
#(
    parameter int unsigned HI_TOP  = 3500,
    parameter int unsigned HI_STEP = 100,
    parameter int unsigned LO_TOP  = 2050,
    parameter int unsigned LO_STEP = 50
) (
    input  logic [4:0] vid,
    output mv_t        ref_val,
    output logic       inh
);
    localparam logic [4:0] INH_CODE = 5'b11111;

    // Select the range by bit 4 and step down by the lower four bits.
    always_comb begin
        inh     = (vid == INH_CODE);
        ref_val = '0;
        if (!inh) begin
            if (vid[4])
                ref_val = mv_t'(HI_TOP - HI_STEP * 32'(vid[3:0]));
            else
                ref_val = mv_t'(LO_TOP - LO_STEP * 32'(vid[3:0]));
        end
    end
endmodule

// File: rtl/cv_ref_latch.sv
// Captures the code once after reset and registers the reference and tracking limits.
// Assumes the code is stable on the first clock after rst_n rises.
module cv_ref_latch
    import core_vsup_pkg::*;
#(
    parameter int unsigned HI_TRIP_PCT = 110,
    parameter int unsigned HI_CLR_PCT  = 108,
    parameter int unsigned LO_TRIP_PCT = 91,
    parameter int unsigned LO_CLR_PCT  = 93,
    parameter int unsigned OV_PCT      = 115
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] vid,
    output mv_t        ref_q,
    output logic       inh_q,
    output lim_t       lim_q,
    output logic       valid_q
);
    mv_t  dec_ref;
    logic dec_inh;

    cv_vid_decode i_dec (
        .vid     (vid),
        .ref_val (dec_ref),
        .inh     (dec_inh)
    );

    // Take the code and derive every limit on the first clock out of reset only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q   <= '0;
            inh_q   <= 1'b0;
            lim_q   <= '0;
            valid_q <= 1'b0;
        end else if (!valid_q) begin
            ref_q         <= dec_ref;
            inh_q         <= dec_inh;
            lim_q.hi_trip <= scale_pct(dec_ref, HI_TRIP_PCT);
            lim_q.hi_clr  <= scale_pct(dec_ref, HI_CLR_PCT);
            lim_q.lo_trip <= scale_pct(dec_ref, LO_TRIP_PCT);
            lim_q.lo_clr  <= scale_pct(dec_ref, LO_CLR_PCT);
            lim_q.ov      <= scale_pct(dec_ref, OV_PCT);
            valid_q       <= 1'b1;
        end
    end
endmodule

// File: rtl/cv_hyst_mon.sv
// One-sided level monitor with hysteresis. Under mode: bad when x < trip, good again
// when x >= recover. Over mode: bad when x > trip, good again when x <= recover.
// Holds its state while en is low. Assumes recover lies on the good side of trip.
module cv_hyst_mon
    import core_vsup_pkg::*;
#(
    parameter mon_dir_e DIR       = MON_UNDER,
    parameter bit       RESET_BAD = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  mv_t  x,
    input  mv_t  trip,
    input  mv_t  recover,
    output logic bad_nxt,
    output logic bad
);
    logic set_c, clr_c;

    // Direction picks the comparison sense.
    generate
        if (DIR == MON_UNDER) begin : g_under
            assign set_c = (x < trip);
            assign clr_c = (x >= recover);
        end else begin : g_over
            assign set_c = (x > trip);
            assign clr_c = (x <= recover);
        end
    endgenerate

    // Next state: set wins, clear only from bad, otherwise hold.
    always_comb begin
        bad_nxt = bad;
        if (en) begin
            if (set_c)
                bad_nxt = 1'b1;
            else if (clr_c)
                bad_nxt = 1'b0;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) bad <= RESET_BAD;
        else        bad <= bad_nxt;
    end
endmodule

// File: rtl/core_vsup.sv
// Core voltage supervisor top. Decodes the code once, then keeps a power-good register,
// an immediate over-voltage trip and a pre-reset clamp request.
// Assumes millivolt samples that are synchronous to clk.
module core_vsup
    import core_vsup_pkg::*;
#(
    parameter int unsigned IO_RISE_MV = 2550,
    parameter int unsigned IO_HYS_MV  = 100,
    parameter int unsigned CLAMP_MV   = 1260,
    parameter int unsigned N_LIN      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       vid,
    input  logic [MV_W-1:0]  core_mv,
    input  logic [MV_W-1:0]  io_mv,
    input  logic [N_LIN-1:0] lin_uv,
    input  logic             por_done,
    output logic [MV_W-1:0]  ref_mv,
    output logic             pgood,
    output logic             ov_trip,
    output logic             clamp_req,
    output logic             inhibit
);
    localparam mv_t IO_CLR  = mv_t'(IO_RISE_MV);
    localparam mv_t IO_TRIP = mv_t'(IO_RISE_MV - IO_HYS_MV);
    localparam mv_t CLAMP_L = mv_t'(CLAMP_MV);

    lim_t lim;
    logic vid_valid;
    logic mon_en;
    logic hi_nxt, hi_bad, lo_nxt, lo_bad, io_nxt, io_bad;

    cv_ref_latch i_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .vid     (vid),
        .ref_q   (ref_mv),
        .inh_q   (inhibit),
        .lim_q   (lim),
        .valid_q (vid_valid)
    );

    assign mon_en = vid_valid && !inhibit;

    cv_hyst_mon #(.DIR(MON_OVER), .RESET_BAD(1'b0)) i_core_hi (
        .clk(clk), .rst_n(rst_n), .en(mon_en), .x(core_mv),
        .trip(lim.hi_trip), .recover(lim.hi_clr), .bad_nxt(hi_nxt), .bad(hi_bad)
    );

    cv_hyst_mon #(.DIR(MON_UNDER), .RESET_BAD(1'b1)) i_core_lo (
        .clk(clk), .rst_n(rst_n), .en(mon_en), .x(core_mv),
        .trip(lim.lo_trip), .recover(lim.lo_clr), .bad_nxt(lo_nxt), .bad(lo_bad)
    );

    cv_hyst_mon #(.DIR(MON_UNDER), .RESET_BAD(1'b1)) i_io (
        .clk(clk), .rst_n(rst_n), .en(mon_en), .x(io_mv),
        .trip(IO_TRIP), .recover(IO_CLR), .bad_nxt(io_nxt), .bad(io_bad)
    );

    // Power-good register: low in reset, high under inhibit, else all monitors clean.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pgood <= 1'b0;
        else
            pgood <= vid_valid && (inhibit ||
                     (por_done && !hi_nxt && !lo_nxt && !io_nxt && (lin_uv == '0)));
    end

    // Immediate over-voltage trip against the registered limit.
    always_comb ov_trip = mon_en && por_done && (core_mv > lim.ov);

    // Fixed-level clamp request, active only before power-on reset completes.
    always_comb clamp_req = !por_done && (core_mv > CLAMP_L);
endmodule

// File: rtl/cv_checker.sv
// Property checker for core_vsup, bound to every instance.
// Assumes the supervisor's port names and its internal vid_valid signal.
module cv_checker
    import core_vsup_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       por_done,
    input logic [1:0] lin_uv,
    input mv_t        core_mv,
    input mv_t        ref_mv,
    input logic       pgood,
    input logic       ov_trip,
    input logic       clamp_req,
    input logic       inhibit,
    input logic       vid_valid
);
    logic started = 1'b0;
    logic rst_d   = 1'b1;

    // Track whether a clock has occurred and the reset value it saw.
    always_ff @(posedge clk) begin
        started <= 1'b1;
        rst_d   <= rst_n;
    end

    // After any clock taken in reset, pgood must be low.
    always @(negedge clk) begin
        if (started && !rst_d)
            assert_pgood_rst_R11: assert (!pgood) else $error("pgood high after reset clock");
    end

    assert_inhibit_pg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit && $past(inhibit) |-> pgood);

    assert_inhibit_ov_R3: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> !ov_trip);

    assert_clamp_por_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_req |-> !por_done && core_mv > 13'd1260);

    assert_ov_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ov_trip |-> por_done && core_mv > ref_mv);

    assert_ref_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vid_valid && $past(vid_valid) |-> $stable(ref_mv) && $stable(inhibit));

    assert_lin_uv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && pgood && !inhibit |-> $past(lin_uv) == 2'b00 && $past(por_done));
endmodule

bind core_vsup cv_checker i_cv_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_done  (por_done),
    .lin_uv    (lin_uv),
    .core_mv   (core_mv),
    .ref_mv    (ref_mv),
    .pgood     (pgood),
    .ov_trip   (ov_trip),
    .clamp_req (clamp_req),
    .inhibit   (inhibit),
    .vid_valid (vid_valid)
);

// File: tb/test_core_vsup.sv
`timescale 1ns/1ps
// Sweeps all 32 codes with boundary sequences; expected values are computed arithmetically.
module test_core_vsup;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  vid = '0;
    logic [12:0] core_mv = '0;
    logic [12:0] io_mv = '0;
    logic [1:0]  lin_uv = '0;
    logic        por_done = 1'b0;
    logic [12:0] ref_mv;
    logic        pgood, ov_trip, clamp_req, inhibit;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    core_vsup i_core_vsup (
        .clk(clk), .rst_n(rst_n), .vid(vid), .core_mv(core_mv), .io_mv(io_mv),
        .lin_uv(lin_uv), .por_done(por_done), .ref_mv(ref_mv), .pgood(pgood),
        .ov_trip(ov_trip), .clamp_req(clamp_req), .inhibit(inhibit)
    );

    function automatic int exp_ref(int v);
        if (v == 31)   return 0;
        if (v >= 16)   return 3500 - 100 * (v - 16);
        return 2050 - 50 * v;
    endfunction

    function automatic int pct(int r, int p);
        return (r * p) / 100;
    endfunction

    task automatic chk(string req, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d (vid=%b core=%0d io=%0d)",
                     req, got, exp, vid, core_mv, io_mv);
        end
    endtask

    // Apply inputs at the falling edge, let one rising edge pass, settle.
    task automatic step(int c, int io, logic [1:0] uv, logic por);
        @(negedge clk);
        core_mv = 13'(c); io_mv = 13'(io); lin_uv = uv; por_done = por;
        @(posedge clk); #1;
    endtask

    task automatic start(int v, int c);
        @(negedge clk);
        rst_n = 1'b0; vid = 5'(v); core_mv = 13'(c); io_mv = 13'd3300;
        lin_uv = 2'b00; por_done = 1'b1;
        repeat (2) @(posedge clk);
        #1 chk("R11 pgood in reset", pgood, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int v = 0; v < 32; v++) begin
            int r;
            r = exp_ref(v);
            start(v, r);
            chk((v >= 16) ? "R1 ref" : "R2 ref", ref_mv, r);
            chk("R3 inhibit flag", inhibit, (v == 31) ? 1 : 0);
            if (v == 31) begin
                step(8000, 0, 2'b11, 1'b1);
                chk("R3 pgood open", pgood, 1);
                #0 chk("R3 no ov", ov_trip, 0);
                step(0, 0, 2'b00, 1'b1);
                chk("R3 pgood open low core", pgood, 1);
            end else begin
                int ht, hc, lt, lc, ov;
                ht = pct(r, 110); hc = pct(r, 108); lt = pct(r, 91); lc = pct(r, 93);
                ov = pct(r, 115);
                step(r, 3300, 2'b00, 1'b1);  chk("R5 good at ref", pgood, 1);
                step(ht, 3300, 2'b00, 1'b1); chk("R4 at trip", pgood, 1);
                step(ht + 1, 3300, 2'b00, 1'b1); chk("R4 above trip", pgood, 0);
                step(hc + 1, 3300, 2'b00, 1'b1); chk("R4 hold band", pgood, 0);
                step(hc, 3300, 2'b00, 1'b1); chk("R4 recover", pgood, 1);
                step(lt, 3300, 2'b00, 1'b1); chk("R5 at trip", pgood, 1);
                step(lt - 1, 3300, 2'b00, 1'b1); chk("R5 below trip", pgood, 0);
                step(lc - 1, 3300, 2'b00, 1'b1); chk("R5 hold band", pgood, 0);
                step(lc, 3300, 2'b00, 1'b1); chk("R5 recover", pgood, 1);
                @(negedge clk); core_mv = 13'(ov); #1 chk("R8 at limit", ov_trip, 0);
                core_mv = 13'(ov + 1); #1 chk("R8 above limit", ov_trip, 1);
                por_done = 1'b0; #1 chk("R8 gated by por", ov_trip, 0);
                por_done = 1'b1;
            end
        end

        // Remaining checks on code 01010 (ref 1550).
        start(10, 1550);
        step(1550, 3300, 2'b00, 1'b1); chk("R6 good", pgood, 1);
        step(1550, 2450, 2'b00, 1'b1); chk("R6 at trip", pgood, 1);
        step(1550, 2449, 2'b00, 1'b1); chk("R6 below trip", pgood, 0);
        step(1550, 2549, 2'b00, 1'b1); chk("R6 hold band", pgood, 0);
        step(1550, 2550, 2'b00, 1'b1); chk("R6 recover", pgood, 1);
        step(1550, 3300, 2'b01, 1'b1); chk("R7 lin_uv bit0", pgood, 0);
        step(1550, 3300, 2'b10, 1'b1); chk("R7 lin_uv bit1", pgood, 0);
        step(1550, 3300, 2'b00, 1'b0); chk("R7 por low", pgood, 0);
        chk("R9 no clamp at 1550 before? core>1260", clamp_req, 1);
        step(1260, 3300, 2'b00, 1'b0); chk("R9 at clamp level", clamp_req, 0);
        step(1261, 3300, 2'b00, 1'b0); chk("R9 above clamp level", clamp_req, 1);
        step(1261, 3300, 2'b00, 1'b1); chk("R9 released by por", clamp_req, 0);
        step(1550, 3300, 2'b00, 1'b1); chk("R11 one-cycle update", pgood, 1);
        @(negedge clk); vid = 5'b10000;
        step(1550, 3300, 2'b00, 1'b1);
        chk("R10 ref unchanged", ref_mv, 1550);
        chk("R10 pgood on old ref", pgood, 1);
        @(negedge clk); vid = 5'b11111;
        step(1550, 3300, 2'b00, 1'b1);
        chk("R10 no late inhibit", inhibit, 0);
        @(negedge clk); core_mv = 13'd1800; #1 chk("R10 ov on old limit", ov_trip, 1);
        @(negedge clk); rst_n = 1'b0; core_mv = 13'd1550;
        @(posedge clk); #1 chk("R11 reset drops pgood", pgood, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule